// File: doc/BRIEF.md
# Slow-to-Fast Lane Serializer

This block narrows a wide parallel bus so that fewer pins carry it. A word of RATIO lanes, each LANE_W bits wide, is taken once per slow clock period. It is then sent out one lane at a time on a LANE_W-bit output that runs on a fast clock. The fast clock is exactly RATIO times the slow one and has its rising edges phase-aligned with it. A wrap-around select counter in the fast domain steps the output multiplexer through the lanes, lowest lane first. A one-cycle frame marker goes out alongside lane 0, so that an external capture instrument can rebuild the original words.

Control sits in a two-state machine in the fast domain. After reset it is in ST_WAIT_BOUNDARY, with the output held at zero and the marker low. It watches a toggle flag that the slow domain flips at every capture. On the first flip it takes the transition boundary_seen into ST_STREAM. It then stays in ST_STREAM, a state with no exit transition, until reset, and the select counter runs freely there. The default build is an 18-bit lane and a ratio of 4. Elaboration stops with an error if RATIO is below 2.

Top module: `lane_serializer`

## Requirements
- R1: `word_in` is sampled only on the rising edge of `clk_slow`. Lane k of a captured word is bits [k*LANE_W + LANE_W-1 : k*LANE_W].
- R2: Lane k of the word captured at a rising `clk_slow` edge is driven on `lane_out` for the fast cycle that starts at the (k+1)-th rising `clk_fast` edge after that slow edge.
- R3: The lane select counts 0, 1, …, RATIO-1 and wraps back to 0, one step per fast cycle, with no gap between words. This holds when RATIO is not a power of two.
- R4: `frame_sync` is high for exactly one fast cycle in every RATIO. That cycle is the one in which lane 0 is driven.
- R5: While `rst_n` is low, and after its release until the first lane 0 appears, `lane_out` is all zeros and `frame_sync` is low. Reset acts asynchronously.
- R6: Once streaming, the lane sequence is never restarted. A change of `word_in` between slow edges has no effect on any driven lane.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_slow | input | 1 | Slow clock, one word per rising edge |
| clk_fast | input | 1 | Fast clock, RATIO times `clk_slow`, rising edges aligned |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| word_in | input | LANE_W*RATIO | Wide input word |
| lane_out | output | LANE_W | Serialized lane, one per fast cycle |
| frame_sync | output | 1 | High during the cycle that carries lane 0 |

## Verification
The bench builds the block with LANE_W = 18 and RATIO = 3. A ratio that is not a power of two makes the select counter take its explicit wrap from 2 to 0. It also leaves one select code unused, which the multiplexer must never reach. With 54-bit words, distinct patterns in each 18-bit lane show any lane swap or bit shift directly. Three fast cycles per slow period also give room to glitch `word_in` between slow edges, and to reset in the middle of a word and restart.

// File: rtl/lsr_pkg.sv
package lsr_pkg;
    typedef enum logic [0:0] {
        ST_WAIT_BOUNDARY = 1'b0,
        ST_STREAM        = 1'b1
    } lsr_state_e;
endpackage

// File: rtl/lsr_hold_reg.sv
// Slow-domain capture register and frame toggle flag.
module lsr_hold_reg #(
    parameter int WORD_W = 72
) (
    input  logic              clk_slow,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] word_in,
    output logic [WORD_W-1:0] hold_word,
    output logic              frame_tog
);
    always_ff @(posedge clk_slow or negedge rst_n) begin
        if (!rst_n) begin
            hold_word <= '0;
            frame_tog <= 1'b0;
        end else begin
            hold_word <= word_in;
            frame_tog <= ~frame_tog;
        end
    end
endmodule

// File: rtl/lsr_slice_fsm.sv
// Fast-domain state machine and wrap-around lane select counter.
module lsr_slice_fsm
    import lsr_pkg::*;
#(
    parameter int RATIO = 4,
    localparam int SEL_W = (RATIO > 1) ? $clog2(RATIO) : 1
) (
    input  logic             clk_fast,
    input  logic             rst_n,
    input  logic             frame_tog,
    output logic             drive_en,
    output logic [SEL_W-1:0] drive_sel
);
    localparam logic [SEL_W-1:0] SEL_LAST = SEL_W'(RATIO - 1);

    lsr_state_e       state_q, state_d;
    logic [SEL_W-1:0] cnt_q, cnt_d;
    logic             tog_seen_q;
    logic             boundary_seen;

    assign boundary_seen = (frame_tog != tog_seen_q);

    // State register process
    always_ff @(posedge clk_fast or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_WAIT_BOUNDARY;
            cnt_q      <= '0;
            tog_seen_q <= 1'b0;
        end else begin
            state_q    <= state_d;
            cnt_q      <= cnt_d;
            tog_seen_q <= frame_tog;
        end
    end

    // Next-state and output process
    always_comb begin
        state_d   = state_q;
        cnt_d     = cnt_q;
        drive_en  = 1'b0;
        drive_sel = '0;
        unique case (state_q)
            ST_WAIT_BOUNDARY: begin
                if (boundary_seen) begin
                    state_d   = ST_STREAM;
                    drive_en  = 1'b1;
                    drive_sel = '0;
                    cnt_d     = SEL_W'(1);
                end
            end
            ST_STREAM: begin
                drive_en  = 1'b1;
                drive_sel = cnt_q;
                cnt_d     = (cnt_q == SEL_LAST) ? '0 : cnt_q + SEL_W'(1);
            end
            default: state_d = ST_WAIT_BOUNDARY;
        endcase
    end

    assert_sel_range_R3: assert property (@(posedge clk_fast) disable iff (!rst_n)
        drive_en |-> (32'(drive_sel) < RATIO));

    assert_wrap_R3: assert property (@(posedge clk_fast) disable iff (!rst_n)
        (state_q == ST_STREAM && cnt_q == SEL_LAST) |=> (cnt_q == '0));

    assert_no_restart_R6: assert property (@(posedge clk_fast) disable iff (!rst_n)
        (state_q == ST_STREAM) |=> (state_q == ST_STREAM));
endmodule

// File: rtl/lsr_slice_mux.sv
// Lane multiplexer over the held word.
module lsr_slice_mux #(
    parameter int LANE_W = 18,
    parameter int RATIO  = 4,
    localparam int SEL_W  = (RATIO > 1) ? $clog2(RATIO) : 1,
    localparam int WORD_W = LANE_W * RATIO
) (
    input  logic [WORD_W-1:0] hold_word,
    input  logic [SEL_W-1:0]  sel,
    output logic [LANE_W-1:0] lane
);
    logic [LANE_W-1:0] lanes [RATIO];

    for (genvar g = 0; g < RATIO; g++) begin : g_lane
        assign lanes[g] = hold_word[g*LANE_W +: LANE_W];
    end

    always_comb begin
        lane = '0;
        for (int k = 0; k < RATIO; k++) begin
            if (32'(sel) == k) lane = lanes[k];
        end
    end
endmodule

// File: rtl/lsr_out_stage.sv
// Output register for lane data and frame marker.
module lsr_out_stage #(
    parameter int LANE_W = 18,
    parameter int SEL_W  = 2
) (
    input  logic              clk_fast,
    input  logic              rst_n,
    input  logic              drive_en,
    input  logic [SEL_W-1:0]  drive_sel,
    input  logic [LANE_W-1:0] lane_in,
    output logic [LANE_W-1:0] lane_out,
    output logic              frame_sync
);
    always_ff @(posedge clk_fast or negedge rst_n) begin
        if (!rst_n) begin
            lane_out   <= '0;
            frame_sync <= 1'b0;
        end else if (drive_en) begin
            lane_out   <= lane_in;
            frame_sync <= (drive_sel == '0);
        end else begin
            lane_out   <= '0;
            frame_sync <= 1'b0;
        end
    end

    assert_sync_single_R4: assert property (@(posedge clk_fast) disable iff (!rst_n)
        frame_sync |=> !frame_sync);

    assert_idle_quiet_R5: assert property (@(posedge clk_fast) disable iff (!rst_n)
        !drive_en |=> (lane_out == '0 && !frame_sync));
endmodule

// File: rtl/lane_serializer.sv
module lane_serializer #(
    parameter int LANE_W = 18,
    parameter int RATIO  = 4,
    localparam int SEL_W  = (RATIO > 1) ? $clog2(RATIO) : 1,
    localparam int WORD_W = LANE_W * RATIO
) (
    input  logic              clk_slow,
    input  logic              clk_fast,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] word_in,
    output logic [LANE_W-1:0] lane_out,
    output logic              frame_sync
);
    if (RATIO < 2) begin : g_bad_ratio
        $error("lane_serializer: RATIO must be at least 2");
    end

    logic [WORD_W-1:0] hold_word;
    logic              frame_tog;
    logic              drive_en;
    logic [SEL_W-1:0]  drive_sel;
    logic [LANE_W-1:0] lane_sel;

    lsr_hold_reg #(.WORD_W(WORD_W)) u_hold (
        .clk_slow  (clk_slow),
        .rst_n     (rst_n),
        .word_in   (word_in),
        .hold_word (hold_word),
        .frame_tog (frame_tog)
    );

    lsr_slice_fsm #(.RATIO(RATIO)) u_fsm (
        .clk_fast  (clk_fast),
        .rst_n     (rst_n),
        .frame_tog (frame_tog),
        .drive_en  (drive_en),
        .drive_sel (drive_sel)
    );

    lsr_slice_mux #(.LANE_W(LANE_W), .RATIO(RATIO)) u_mux (
        .hold_word (hold_word),
        .sel       (drive_sel),
        .lane      (lane_sel)
    );

    lsr_out_stage #(.LANE_W(LANE_W), .SEL_W(SEL_W)) u_out (
        .clk_fast   (clk_fast),
        .rst_n      (rst_n),
        .drive_en   (drive_en),
        .drive_sel  (drive_sel),
        .lane_in    (lane_sel),
        .lane_out   (lane_out),
        .frame_sync (frame_sync)
    );
endmodule

// File: tb/test_lane_serializer.sv
module test_lane_serializer;
    localparam int LANE_W = 18;
    localparam int RATIO  = 3;
    localparam int WORD_W = LANE_W * RATIO;
    localparam int NV     = 6;

    // Stimulus words; expected lanes are the 18-bit fields of each word.
    localparam logic [WORD_W-1:0] VEC [NV] = '{
        {18'h3FFFF, 18'h00000, 18'h2AAAA},
        {18'h15555, 18'h00001, 18'h20000},
        {18'h12345, 18'h0ABCD, 18'h3C3C3},
        {18'h00000, 18'h00000, 18'h00000},
        {18'h3FFFF, 18'h3FFFF, 18'h3FFFF},
        {18'h01234, 18'h36789, 18'h0F00F}
    };
    localparam logic [WORD_W-1:0] JUNK = {3{18'h2D2D2}};

    logic              clk_slow = 1'b0;
    logic              clk_fast = 1'b0;
    logic              rst_n    = 1'b0;
    logic [WORD_W-1:0] word_in  = '0;
    logic [LANE_W-1:0] lane_out;
    logic              frame_sync;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  finished = 1'b0;

    always #4  clk_fast = ~clk_fast;   // 125 MHz
    always #12 clk_slow = ~clk_slow;   // fast / RATIO, rising edges aligned

    lane_serializer #(.LANE_W(LANE_W), .RATIO(RATIO)) i_lane_serializer (
        .clk_slow   (clk_slow),
        .clk_fast   (clk_fast),
        .rst_n      (rst_n),
        .word_in    (word_in),
        .lane_out   (lane_out),
        .frame_sync (frame_sync)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk_fast);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=running expected=done");
        finish_run();
    end

    initial begin
        // R5: outputs quiet during reset
        repeat (3) @(negedge clk_fast);
        check("R5 lane in reset", 32'(lane_out), 32'h0);
        check("R5 sync in reset", 32'(frame_sync), 32'h0);

        @(negedge clk_slow);
        rst_n   = 1'b1;
        word_in = VEC[0];
        fork
            begin
                for (int i = 1; i < NV; i++) begin
                    @(negedge clk_slow);
                    word_in = VEC[i];
                    if (i % 2 == 1) begin
                        // R6: glitch between slow edges, restored before capture
                        #2 word_in = JUNK;
                        #8 word_in = VEC[i];
                    end
                end
            end
            begin
                @(posedge clk_slow);
                @(negedge clk_fast);
                check("R5 lane before first lane 0", 32'(lane_out), 32'h0);
                check("R5 sync before first lane 0", 32'(frame_sync), 32'h0);
                for (int j = 0; j < NV * RATIO; j++) begin
                    @(negedge clk_fast);
                    check(((j / RATIO) % 2 == 1) ? "R6 lane after glitch" : "R1 R2 R3 lane",
                          32'(lane_out), 32'(VEC[j / RATIO][(j % RATIO) * LANE_W +: LANE_W]));
                    check("R4 sync", 32'(frame_sync), 32'(j % RATIO == 0));
                end
            end
        join

        // R6: stream continues with the last word held, no restart
        word_in = VEC[NV-1];
        for (int j = 0; j < 2 * RATIO; j++) begin
            @(negedge clk_fast);
            check("R6 continuous lane", 32'(lane_out),
                  32'(VEC[NV-1][((j + 0) % RATIO) * LANE_W +: LANE_W]));
            check("R4 continuous sync", 32'(frame_sync), 32'(j % RATIO == 0));
        end

        // R5: asynchronous reset mid-word, then restart
        @(negedge clk_fast);
        #1 rst_n = 1'b0;
        #1;
        check("R5 async lane clear", 32'(lane_out), 32'h0);
        check("R5 async sync clear", 32'(frame_sync), 32'h0);
        repeat (4) @(negedge clk_fast);
        check("R5 lane held in reset", 32'(lane_out), 32'h0);
        @(negedge clk_slow);
        rst_n   = 1'b1;
        word_in = VEC[2];
        @(posedge clk_slow);
        @(negedge clk_fast);
        check("R5 lane quiet after release", 32'(lane_out), 32'h0);
        for (int k = 0; k < RATIO; k++) begin
            @(negedge clk_fast);
            check("R2 lane after restart", 32'(lane_out), 32'(VEC[2][k * LANE_W +: LANE_W]));
            check("R4 sync after restart", 32'(frame_sync), 32'(k == 0));
        end

        finish_run();
    end
endmodule